// File: doc/BRIEF.md
# Flash Bad Block Scanner

This block walks every erase block of a NAND-style flash array once, normally just after power-up, and records which blocks carry a factory defect marker. When started, it visits the blocks in ascending order. For each block it reads the first byte of the spare area from the first two pages. The reads go through a simple request port that returns one byte for a given row and column. A block whose marker byte is anything other than FFh on either page is recorded as defective.

The result is a one-bit-per-block defect map, which the rest of the system reads through a combinational query port to build its remapping tables. The block also keeps a running count of defective blocks and raises two flags. The first flag rises when more blocks are defective than the array is guaranteed to have. The second rises when block 0, which is guaranteed good, comes back marked. A start pulse begins a scan. A one-cycle done pulse ends it, and the final count is already on its output in that cycle.

The row address sent to the flash is the block number in the upper bits above a 6-bit page number. The column is fixed at the first spare byte, 2048, just past the 2048-byte data area.

Top module: `bad_block_scanner`

## Requirements
- R1: After a start is accepted, read requests are issued for blocks 0 to NUM_BLOCKS-1 in ascending order, page 0 and then page 1 for each block, with rd_row_o equal to the block number in bits 14:6 and the page number in bits 5:0.
- R2: Every read request carries column 2048 on rd_col_o.
- R3: rd_req_o is a single-cycle pulse, and no new request is issued until rd_valid_i has returned the byte for the previous one.
- R4: A block is defective when the returned byte is not FFh on page 0 or on page 1. After the scan, q_bad_o is 1 for each defective block selected on q_blk_i and 0 for each good one.
- R5: bad_count_o equals the number of defective blocks found, and holds that final value in the cycle where done_o is high.
- R6: over_limit_o is 1 after the scan when bad_count_o exceeds 10, and stays 0 when exactly 10 blocks are defective.
- R7: blk0_bad_o is 1 after the scan exactly when block 0 was found defective.
- R8: done_o is high for exactly one cycle per scan. busy_o is high from the cycle after start is accepted through the done cycle, and no request is issued while busy_o is low.
- R9: A start pulse while busy_o is high is ignored, and the scan in progress continues unchanged.
- R10: Accepting a start clears the defect map, the count and both flags, so the results reflect only the new scan.
- R11: After reset, busy_o, done_o, rd_req_o, the count, both flags and every map bit read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a scan (accepted when idle) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| bad_count_o | output | 10 | Number of defective blocks found |
| over_limit_o | output | 1 | Defect count exceeds the guaranteed maximum |
| blk0_bad_o | output | 1 | Block 0 was found defective |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_row_o | output | 15 | Row of the request: block above page |
| rd_col_o | output | 12 | Column of the request (spare marker byte) |
| rd_valid_i | input | 1 | Returned byte is valid |
| rd_data_i | input | 8 | Returned marker byte |
| q_blk_i | input | 9 | Block selected for a map query |
| q_bad_o | output | 1 | Defect bit of the selected block |

## Verification
The assertions take for granted that the read port answers each request with exactly one rd_valid_i pulse, some cycles later, and never pulses rd_valid_i when no request is pending. A stray pulse while the scanner is issuing, idle or finishing would be dropped silently and break the one-request-in-flight discipline they check. The bench responder raises rd_valid_i only for a request it has seen, with a latency of zero to two idle cycles that varies with the row. It also injects start pulses only through the normal start input, including one in the middle of a scan.

// File: rtl/bbs_pkg.sv
// Shared types for the bad block scanner.
package bbs_pkg;
    // Sequencer states: waiting, sending a request, waiting for its byte, final pulse.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } scan_st_t;
endpackage

// File: rtl/bbs_seq.sv
// Scan sequencer: steps through every block, reads the marker byte of pages
// 0 and 1, and reports one verdict per block on the commit strobe.
// Assumes the read port answers every request with exactly one valid pulse.
module bbs_seq
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 512,
    parameter int PAGE_W     = 6,
    parameter logic [7:0] GOOD_BYTE = 8'hFF,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ROW_W     = BLK_W + PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_valid_i,
    input  logic [7:0]       rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             rd_req_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic             clear_o,
    output logic             commit_o,
    output logic             commit_bad_o,
    output logic [BLK_W-1:0] commit_blk_o
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_st_t         state_q;
    logic [BLK_W-1:0] blk_q;
    logic             page_q;
    logic             bad_acc_q;
    logic             byte_bad;

    // Marker byte verdict for the byte currently returned.
    always_comb byte_bad = (rd_data_i != GOOD_BYTE);

    // State, block counter, page select and page-0 verdict accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blk_q     <= '0;
            page_q    <= 1'b0;
            bad_acc_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_ISSUE;
                        blk_q     <= '0;
                        page_q    <= 1'b0;
                        bad_acc_q <= 1'b0;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_valid_i) begin
                        if (!page_q) begin
                            page_q    <= 1'b1;
                            bad_acc_q <= byte_bad;
                            state_q   <= ST_ISSUE;
                        end else begin
                            page_q    <= 1'b0;
                            bad_acc_q <= 1'b0;
                            if (blk_q == LAST_BLK) begin
                                state_q <= ST_FINISH;
                            end else begin
                                blk_q   <= blk_q + BLK_W'(1);
                                state_q <= ST_ISSUE;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request and strobe outputs decoded from the state.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_FINISH);
        rd_req_o     = (state_q == ST_ISSUE);
        rd_row_o     = {blk_q, {(PAGE_W-1){1'b0}}, page_q};
        clear_o      = (state_q == ST_IDLE) && start_i;
        commit_o     = (state_q == ST_WAIT) && rd_valid_i && page_q;
        commit_bad_o = bad_acc_q | byte_bad;
        commit_blk_o = blk_q;
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);                                          // R3
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> !rd_req_o);                         // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));                                 // R8
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);                                           // R8
    AST_PAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_row_o[0]) |-> $stable(rd_row_o[ROW_W-1:PAGE_W])); // R1
endmodule

// File: rtl/bbs_map.sv
// Defect map: one bit per block, cleared as a scan starts, set on a defective
// verdict, read combinationally by block number.
// Assumes set and clear never arrive in the same cycle (start is only accepted when idle).
module bbs_map #(
    parameter int NUM_BLOCKS = 512,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic [BLK_W-1:0] set_blk_i,
    input  logic [BLK_W-1:0] q_blk_i,
    output logic             q_bad_o
);
    logic [NUM_BLOCKS-1:0] map_q;

    // Map storage: reset and start clear it, a defective verdict sets one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            map_q <= '0;
        end else if (set_i) begin
            map_q[set_blk_i] <= 1'b1;
        end
    end

    generate
        if ((2 ** BLK_W) == NUM_BLOCKS) begin : g_full
            // Query port when every block number is a real block.
            always_comb q_bad_o = map_q[q_blk_i];
        end else begin : g_guard
            // Query port with out-of-range block numbers reading as good.
            always_comb q_bad_o = (int'(q_blk_i) < NUM_BLOCKS) ? map_q[q_blk_i] : 1'b0;
        end
    endgenerate

    AST_MAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> map_q[$past(set_blk_i)]);                   // R4
    AST_MAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (map_q == '0));                                         // R10
endmodule

// File: rtl/bbs_tally.sv
// Defect tally: counts defective verdicts and keeps the over-limit and
// block-0 anomaly flags. Assumes at most one verdict per cycle.
module bbs_tally #(
    parameter int NUM_BLOCKS = 512,
    parameter int MAX_BAD    = 10,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             commit_i,
    input  logic             bad_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic [CNT_W-1:0] count_o,
    output logic             over_o,
    output logic             blk0_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

    // Count and flags: cleared at start, updated on each defective verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= '0;
            over_o  <= 1'b0;
            blk0_o  <= 1'b0;
        end else if (commit_i && bad_i) begin
            count_o <= count_o + CNT_W'(1);
            if (count_o >= LIMIT) over_o <= 1'b1;
            if (blk_i == '0)      blk0_o <= 1'b1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1))); // R5
    AST_OVER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (count_o > LIMIT));                                    // R6
    AST_OVER_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o > LIMIT) |-> over_o);                                    // R6
    AST_BLK0_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        blk0_o |-> (count_o != '0));                                      // R7
endmodule

// File: rtl/bad_block_scanner.sv
// Bad block scanner top: joins the sequencer, defect map and tally.
// Assumes the read port returns one byte per request and no unsolicited bytes.
module bad_block_scanner #(
    parameter int NUM_BLOCKS = 512,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int MARK_COL   = 2048,
    parameter int MAX_BAD    = 10,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ROW_W     = BLK_W + PAGE_W,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] bad_count_o,
    output logic             over_limit_o,
    output logic             blk0_bad_o,
    output logic             rd_req_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [COL_W-1:0] rd_col_o,
    input  logic             rd_valid_i,
    input  logic [7:0]       rd_data_i,
    input  logic [BLK_W-1:0] q_blk_i,
    output logic             q_bad_o
);
    logic             clear;
    logic             commit;
    logic             commit_bad;
    logic [BLK_W-1:0] commit_blk;

    // Marker column is fixed: first byte of the spare area.
    always_comb rd_col_o = COL_W'(MARK_COL);

    bbs_seq #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .PAGE_W     (PAGE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .rd_valid_i   (rd_valid_i),
        .rd_data_i    (rd_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .rd_req_o     (rd_req_o),
        .rd_row_o     (rd_row_o),
        .clear_o      (clear),
        .commit_o     (commit),
        .commit_bad_o (commit_bad),
        .commit_blk_o (commit_blk)
    );

    bbs_map #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clear),
        .set_i     (commit && commit_bad),
        .set_blk_i (commit_blk),
        .q_blk_i   (q_blk_i),
        .q_bad_o   (q_bad_o)
    );

    bbs_tally #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .MAX_BAD    (MAX_BAD)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear),
        .commit_i (commit),
        .bad_i    (commit_bad),
        .blk_i    (commit_blk),
        .count_o  (bad_count_o),
        .over_o   (over_limit_o),
        .blk0_o   (blk0_bad_o)
    );

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);                       // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bad_count_o) <= NUM_BLOCKS);                                 // R5
endmodule

// File: tb/sim_bad_block_scanner.sv
// Bench: behavioural reference model (request queue, busy model, per-block
// verdicts) compared on every clock against the scanner.
module sim_bad_block_scanner;
    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, over_limit_o, blk0_bad_o, rd_req_o, q_bad_o;
    logic [9:0]  bad_count_o;
    logic [14:0] rd_row_o;
    logic [11:0] rd_col_o;
    logic        rd_valid_i = 1'b0;
    logic [7:0]  rd_data_i = 8'h00;
    logic [8:0]  q_blk_i = 9'd0;

    int checks = 0;
    int fails  = 0;
    int mode   = 0;
    int cycles = 0;
    bit in_reset = 1'b1;
    bit scan_done = 1'b0;

    logic [14:0] exp_rows[$];
    bit   pend = 1'b0;
    int   wait_c = 0;
    logic [14:0] pend_row = '0;
    bit   exp_busy = 1'b0;
    bit   prev_start = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;

    always #4 clk = ~clk;

    bad_block_scanner u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .done_o(done_o), .bad_count_o(bad_count_o), .over_limit_o(over_limit_o),
        .blk0_bad_o(blk0_bad_o), .rd_req_o(rd_req_o), .rd_row_o(rd_row_o),
        .rd_col_o(rd_col_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .q_blk_i(q_blk_i), .q_bad_o(q_bad_o)
    );

    // Marker byte stored in the simulated array for each scenario.
    function automatic logic [7:0] marker(int m, int blk, int pg);
        case (m)
            0: if (blk % 97 == 5 && pg == 0) return 8'hFE;
               else if (blk == 511 && pg == 1) return 8'h00;
            1: if (blk % 40 == 3 && pg == 1) return 8'h7F;
               else if (blk == 0 && pg == 1) return 8'h00;
            2: if (blk >= 1 && blk <= 10 && pg == 0) return 8'h00;
            3: if (blk >= 1 && blk <= 11 && pg == (blk % 2)) return 8'h5A;
            default: ;
        endcase
        return 8'hFF;
    endfunction

    function automatic bit exp_bad(int m, int blk);
        return (marker(m, blk, 0) != 8'hFF) || (marker(m, blk, 1) != 8'hFF);
    endfunction

    function automatic int exp_count(int m);
        int n = 0;
        for (int b = 0; b < NB; b++) if (exp_bad(m, b)) n++;
        return n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model, responder and per-clock comparison.
    always @(negedge clk) begin
        rd_valid_i <= 1'b0;
        if (!in_reset) begin
            exp_busy = (prev_start && !prev_busy) ? 1'b1 : (prev_done ? 1'b0 : exp_busy);
            check(busy_o == exp_busy, "R8 busy", busy_o, exp_busy);
            if (pend) begin
                if (wait_c == 0) begin
                    rd_valid_i <= 1'b1;
                    rd_data_i  <= marker(mode, int'(pend_row[14:6]), int'(pend_row[5:0]));
                    pend = 1'b0;
                end else begin
                    wait_c--;
                end
            end
            if (rd_req_o) begin
                check(!pend, "R3 request while one in flight", 1, 0);
                check(exp_rows.size() != 0, "R1 unexpected request", int'(rd_row_o), -1);
                if (exp_rows.size() != 0) begin
                    check(rd_row_o == exp_rows[0], "R1 row", int'(rd_row_o), int'(exp_rows[0]));
                    void'(exp_rows.pop_front());
                end
                check(rd_col_o == 12'd2048, "R2 column", int'(rd_col_o), 2048);
                pend     = 1'b1;
                pend_row = rd_row_o;
                wait_c   = int'(rd_row_o) % 3;
            end
            if (!busy_o) check(!rd_req_o, "R8 request while idle", 1, 0);
            if (done_o) begin
                check(!prev_done, "R8 done width", 1, 0);
                check(int'(bad_count_o) == exp_count(mode), "R5 count at done",
                      int'(bad_count_o), exp_count(mode));
                check(over_limit_o == (exp_count(mode) > 10), "R6 over limit",
                      over_limit_o, exp_count(mode) > 10);
                check(blk0_bad_o == exp_bad(mode, 0), "R7 block 0 flag",
                      blk0_bad_o, exp_bad(mode, 0));
                check(exp_rows.size() == 0, "R1 all rows read", exp_rows.size(), 0);
                scan_done = 1'b1;
            end
            prev_start = start_i;
            prev_busy  = busy_o;
            prev_done  = done_o;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_scan(int m, bit poke_mid);
        mode = m;
        scan_done = 1'b0;
        for (int b = 0; b < NB; b++) begin
            exp_rows.push_back({9'(b), 6'd0});
            exp_rows.push_back({9'(b), 6'd1});
        end
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        // R10: results of the previous scan are gone once the new one starts.
        @(negedge clk);
        check(bad_count_o == 10'd0 && !over_limit_o && !blk0_bad_o, "R10 cleared at start",
              int'(bad_count_o), 0);
        if (poke_mid) begin
            // R9: a start while busy leaves the request sequence untouched.
            repeat (700) @(posedge clk);
            #1 start_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0;
        end
        while (!scan_done) @(posedge clk);
        @(posedge clk);
        for (int b = 0; b < NB; b++) begin
            #1 q_blk_i = 9'(b);
            @(negedge clk);
            check(q_bad_o == exp_bad(m, b), "R4 map bit", q_bad_o, exp_bad(m, b));
            @(posedge clk);
        end
        check(!busy_o, "R8 idle after scan", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        in_reset = 1'b0;
        @(negedge clk);
        // R11: reset state.
        check(!busy_o && !done_o && !rd_req_o, "R11 control outputs", busy_o, 0);
        check(bad_count_o == 10'd0 && !over_limit_o && !blk0_bad_o, "R11 tally", int'(bad_count_o), 0);
        for (int b = 0; b < NB; b += 37) begin
            q_blk_i = 9'(b);
            #1;
            check(!q_bad_o, "R11 map clear", q_bad_o, 0);
        end
        run_scan(0, 1'b0);  // scattered defects, page 0 and page 1 markers
        run_scan(1, 1'b0);  // 14 defects including block 0: both flags
        run_scan(2, 1'b1);  // exactly 10 defects, start pulsed mid-scan
        run_scan(3, 1'b0);  // 11 defects: limit exceeded
        run_scan(0, 1'b0);  // map and flags cleared from the previous scan
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule